// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a synchronous DRAM from reset until the memory is usable. After reset it holds clock enable low and the chip deselected for the power-on pause. It then raises clock enable for one quiet cycle and closes every bank. Eight auto-refresh commands follow at row-cycle spacing, and the mode register is loaded from the configuration inputs. A short settle delay precedes the ready flag. All delays are counted in clock cycles derived from the clock frequency parameter.

Once ready, an interval timer produces a refresh request about every 15.6 µs. Requests that are not yet serviced are held in a saturating counter. The sequencer raises `ref_req` while at least one request is pending. When the user side answers with `ref_grant`, the sequencer takes the bus: it drops `ready`, precharges all banks, waits the precharge time, issues one auto-refresh, waits the row cycle time and then hands the bus back. While it is idle it drives NOP.

States: ST_PWRUP (pause, CKE low) → ST_CKE_ON (one NOP with CKE high) → ST_INIT_PRE → ST_INIT_TRP → ST_INIT_REF → ST_INIT_TRC (back to ST_INIT_REF until eight are done) → ST_MODE_SET → ST_MODE_TMRD → ST_READY. From ST_READY, a grant while a request is pending leads through ST_RF_PRE → ST_RF_TRP → ST_RF_REF → ST_RF_TRC and back to ST_READY.

Top module: `sdram_bringup_seq`

## Requirements
- R1: For PWR_CYC = ceil(200 µs × f) cycles after reset release, and during reset, `sd_cke` is 0, the chip is deselected (cs_n,ras_n,cas_n,we_n = 1111), and `ready` and `ref_req` are 0.
- R2: The next cycle is a NOP (0111) with CKE high. It is followed by precharge-all (0010) with A10=1 and all other address bits 0.
- R3: A command following a precharge comes exactly RP_CYC cycles after it (at least 2). A command following an auto-refresh comes exactly RC_CYC = ceil(70 ns × f) cycles after it. All cycles in between are NOP.
- R4: Exactly 8 auto-refresh commands (0001, address 0) are issued between the initial precharge-all and the mode set.
- R5: The mode set command (0000) carries the burst length code on A2..A0, the burst type (0 sequential, 1 interleave) on A3, the CAS latency code on A6..A4, and zeros on A11..A7.
- R6: After the mode set come MRD_CYC-1 NOP cycles, and then `ready` rises. `ready` is high only while the sequencer is idle, and every idle cycle drives NOP.
- R7: The first `ref_req` rises REFI_CYC = ceil(15.6 µs × f) cycles after `ready` first rises. A new request is generated every REFI_CYC cycles after that.
- R8: `ref_req` is high only while `ready` is high and a request is pending. A `ref_grant` while `ref_req` is low has no effect.
- R9: A grant sampled while `ref_req` is high makes the next cycle a precharge-all with `ready` low. Then follow RP_CYC spacing, one auto-refresh, RC_CYC spacing, and a return to ready.
- R10: Up to 7 ungranted requests are remembered, and further ones are dropped. Each pending request is served by one refresh sequence.
- R11: Clock enable has been high for at least one cycle before any precharge, refresh or mode set command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_interleave | input | 1 | Burst type: 1 selects interleaved order |
| cfg_cas_lat | input | 3 | CAS latency code for the mode word |
| ref_grant | input | 1 | User side yields the bus for a refresh |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus; A10 marks all banks, A11 is the bank select |
| ready | output | 1 | Sequencer idle and the memory usable by the user side |
| ref_req | output | 1 | At least one refresh is pending |

## Verification
The bench checks the full power-up stream cycle by cycle. A pause that is one cycle short or long, a missing quiet CKE cycle, or a seventh or ninth initial refresh would each show up as a mismatched pin pattern. The mode word is checked under two configurations, so swapped or shifted fields are exposed. Refresh requests are left ungranted for nine intervals to reach saturation: a counter that wraps would serve too few refreshes, and one that does not saturate would serve too many. A grant given with nothing pending is checked to leave the bus idle, and a grant given on the cycle a request first appears is checked to start the sequence on the very next cycle.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_CKE_ON,
        ST_INIT_PRE,
        ST_INIT_TRP,
        ST_INIT_REF,
        ST_INIT_TRC,
        ST_MODE_SET,
        ST_MODE_TMRD,
        ST_READY,
        ST_RF_PRE,
        ST_RF_TRP,
        ST_RF_REF,
        ST_RF_TRC
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_SLEEP,
        CMD_NOP,
        CMD_PRE_ALL,
        CMD_REFRESH,
        CMD_MODE
    } seq_cmd_t;

    // Converts a time in ns to clock cycles, rounding up, with a lower bound.
    function automatic int unsigned ns_to_cyc(longint unsigned ns,
                                              longint unsigned khz,
                                              int unsigned     min_cyc);
        longint unsigned c;
        c = (ns * khz + 64'd999_999) / 64'd1_000_000;
        if (c < longint'(min_cyc)) c = longint'(min_cyc);
        return int'(c);
    endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
    parameter int W       = 14,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= W'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdr_refi_tracker.sv
module sdr_refi_tracker #(
    parameter int REFI_CYC = 780,
    parameter int PEND_W   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic served,
    output logic pend_any
);
    localparam int TW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
    localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

    logic [TW-1:0]     tcnt;
    logic [PEND_W-1:0] pend;
    logic              tick;

    assign tick = run && (tcnt == TW'(REFI_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tcnt <= '0;
        else if (!run) tcnt <= '0;
        else if (tick) tcnt <= '0;
        else           tcnt <= tcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend <= '0;
        else if (tick && !served && pend != PMAX)
            pend <= pend + 1'b1;
        else if (served && !tick && pend != '0)
            pend <= pend - 1'b1;
    end

    assign pend_any = (pend != '0);
endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  seq_cmd_t          cmd,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

    always_comb begin
        cke  = 1'b1;
        addr = '0;
        unique case (cmd)
            CMD_SLEEP:   begin cke = 1'b0; {cs_n, ras_n, cas_n, we_n} = 4'b1111; end
            CMD_NOP:     {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            CMD_PRE_ALL: begin {cs_n, ras_n, cas_n, we_n} = 4'b0010; addr = ALL_BANKS; end
            CMD_REFRESH: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            CMD_MODE:    begin {cs_n, ras_n, cas_n, we_n} = 4'b0000; addr = mode_word; end
            default:     {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
    end
endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
    import sdr_seq_pkg::*;
#(
    parameter int CLK_KHZ   = 50_000,
    parameter int PWRUP_NS  = 200_000,
    parameter int TRP_NS    = 20,
    parameter int TRC_NS    = 70,
    parameter int REFI_NS   = 15_600,
    parameter int MRD_CYC   = 2,
    parameter int INIT_REFS = 8,
    parameter int PEND_W    = 3,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              ref_grant,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              ready,
    output logic              ref_req
);
    localparam int PWR_CYC  = ns_to_cyc(PWRUP_NS, CLK_KHZ, 1);
    localparam int RP_CYC   = ns_to_cyc(TRP_NS, CLK_KHZ, 2);
    localparam int RC_CYC   = ns_to_cyc(TRC_NS, CLK_KHZ, 2);
    localparam int REFI_CYC = ns_to_cyc(REFI_NS, CLK_KHZ, 2);
    localparam int MRD_EFF  = (MRD_CYC < 2) ? 2 : MRD_CYC;
    localparam int MAX_A    = (PWR_CYC > RC_CYC) ? PWR_CYC : RC_CYC;
    localparam int MAX_B    = (RP_CYC > MRD_EFF) ? RP_CYC : MRD_EFF;
    localparam int MAX_W    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int WAIT_W   = $clog2(MAX_W + 1);
    localparam int IREF_W   = (INIT_REFS > 1) ? $clog2(INIT_REFS) : 1;

    seq_state_t        state, nxt;
    seq_cmd_t          cmd;
    logic              w_done, w_load;
    logic [WAIT_W-1:0] w_val;
    logic [IREF_W-1:0] iref_cnt;
    logic              last_iref;
    logic              pend_any, served, run;
    logic [ADDR_W-1:0] mode_word;

    assign mode_word = {{(ADDR_W-7){1'b0}}, cfg_cas_lat, cfg_interleave, cfg_burst_len};
    assign last_iref = (iref_cnt == IREF_W'(INIT_REFS - 1));

    sdr_wait_timer #(.W(WAIT_W), .RST_VAL(PWR_CYC - 1)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(w_load), .load_val(w_val), .done(w_done)
    );

    sdr_refi_tracker #(.REFI_CYC(REFI_CYC), .PEND_W(PEND_W)) u_refi (
        .clk(clk), .rst_n(rst_n), .run(run), .served(served), .pend_any(pend_any)
    );

    sdr_cmd_drive #(.ADDR_W(ADDR_W)) u_drive (
        .cmd(cmd), .mode_word(mode_word), .cke(sd_cke), .cs_n(sd_cs_n),
        .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n), .addr(sd_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= nxt;
    end

    // Counts the refreshes of the power-up series
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            iref_cnt <= '0;
        else if (state == ST_INIT_TRC && w_done && !last_iref)
            iref_cnt <= iref_cnt + 1'b1;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PWRUP:     if (w_done) nxt = ST_CKE_ON;
            ST_CKE_ON:    nxt = ST_INIT_PRE;
            ST_INIT_PRE:  nxt = ST_INIT_TRP;
            ST_INIT_TRP:  if (w_done) nxt = ST_INIT_REF;
            ST_INIT_REF:  nxt = ST_INIT_TRC;
            ST_INIT_TRC:  if (w_done) nxt = last_iref ? ST_MODE_SET : ST_INIT_REF;
            ST_MODE_SET:  nxt = ST_MODE_TMRD;
            ST_MODE_TMRD: if (w_done) nxt = ST_READY;
            ST_READY:     if (pend_any && ref_grant) nxt = ST_RF_PRE;
            ST_RF_PRE:    nxt = ST_RF_TRP;
            ST_RF_TRP:    if (w_done) nxt = ST_RF_REF;
            ST_RF_REF:    nxt = ST_RF_TRC;
            ST_RF_TRC:    if (w_done) nxt = ST_READY;
            default:      nxt = ST_PWRUP;
        endcase
    end

    // Outputs per state
    always_comb begin
        cmd     = CMD_NOP;
        w_load  = 1'b0;
        w_val   = '0;
        served  = 1'b0;
        ready   = 1'b0;
        ref_req = 1'b0;
        run     = 1'b1;
        unique case (state)
            ST_PWRUP:     begin cmd = CMD_SLEEP; run = 1'b0; end
            ST_CKE_ON,
            ST_INIT_TRP,
            ST_INIT_TRC,
            ST_MODE_TMRD: run = 1'b0;
            ST_INIT_PRE:  begin cmd = CMD_PRE_ALL; run = 1'b0;
                                w_load = 1'b1; w_val = WAIT_W'(RP_CYC - 2); end
            ST_INIT_REF:  begin cmd = CMD_REFRESH; run = 1'b0;
                                w_load = 1'b1; w_val = WAIT_W'(RC_CYC - 2); end
            ST_MODE_SET:  begin cmd = CMD_MODE; run = 1'b0;
                                w_load = 1'b1; w_val = WAIT_W'(MRD_EFF - 2); end
            ST_READY:     begin ready = 1'b1; ref_req = pend_any; end
            ST_RF_PRE:    begin cmd = CMD_PRE_ALL;
                                w_load = 1'b1; w_val = WAIT_W'(RP_CYC - 2); end
            ST_RF_REF:    begin cmd = CMD_REFRESH; served = 1'b1;
                                w_load = 1'b1; w_val = WAIT_W'(RC_CYC - 2); end
            ST_RF_TRP,
            ST_RF_TRC:    ;
            default:      begin cmd = CMD_SLEEP; run = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk #(
    parameter int RP_CYC = 2,
    parameter int RC_CYC = 4,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              ready,
    input logic              ref_req,
    input logic              ref_grant
);
    logic is_cmd, is_pre, is_ref, is_mode, is_nop;
    logic [15:0] since_ref, since_pre;

    assign is_nop  = !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;
    assign is_cmd  = !sd_cs_n && !is_nop;
    assign is_pre  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010;
    assign is_ref  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001;
    assign is_mode = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_ref <= 16'hFFFF;
            since_pre <= 16'hFFFF;
        end else begin
            if (is_ref)                  since_ref <= 16'd1;
            else if (since_ref != 16'hFFFF) since_ref <= since_ref + 16'd1;
            if (is_pre)                  since_pre <= 16'd1;
            else if (since_pre != 16'hFFFF) since_pre <= since_pre + 16'd1;
        end
    end

    AST_CKE_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |-> $past(sd_cke)); // R11
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_addr[10]); // R2
    AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |-> (int'(since_ref) >= RC_CYC)); // R3
    AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |-> (int'(since_pre) >= RP_CYC)); // R3
    AST_MODE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |-> (sd_addr[ADDR_W-1:7] == '0)); // R5
    AST_READY_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> is_nop); // R6
    AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> ready); // R8
    AST_GRANT_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ref_req && ref_grant) |=> (!ready && is_pre)); // R9
endmodule

bind sdram_bringup_seq sdr_seq_chk #(.RP_CYC(RP_CYC), .RC_CYC(RC_CYC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .ready(ready),
    .ref_req(ref_req), .ref_grant(ref_grant)
);

// File: tb/sdram_bringup_seq_tb.sv
module sdram_bringup_seq_tb;
    // Cycle counts derived from the requirements at 50 MHz
    localparam int PWR  = 200 * 50;
    localparam int RP   = ((20 * 50 + 999) / 1000 < 2) ? 2 : (20 * 50 + 999) / 1000;
    localparam int RC   = (70 * 50 + 999) / 1000;
    localparam int REFI = (15600 * 50 + 999) / 1000;
    localparam int MRD  = 2;
    localparam int PMAX = 7;

    localparam logic [3:0] P_SLEEP = 4'b1111, P_NOP = 4'b0111, P_PRE = 4'b0010,
                           P_REF = 4'b0001, P_MRS = 4'b0000;

    logic clk = 0, rst_n = 0, ref_grant = 0, cfg_interleave = 0;
    logic [2:0] cfg_burst_len = 3'b011, cfg_cas_lat = 3'b010;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, ready, ref_req;
    logic [11:0] sd_addr;
    logic [3:0] pins;

    int checks = 0, failures = 0;

    sdram_bringup_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
        .cfg_cas_lat(cfg_cas_lat), .ref_grant(ref_grant), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
        .ready(ready), .ref_req(ref_req)
    );

    always #10 clk = ~clk;
    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    task automatic chk(input bit ok, input int r, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
        end
    endtask

    // Reference model: queue of expected pin states, pending count, interval timer
    typedef struct packed {
        logic cke; logic [3:0] pins; logic [11:0] addr; logic rdy; logic srv; logic [3:0] tag;
    } ent_t;

    ent_t m_q[$];
    bit   m_built = 0, m_run = 0;
    int   m_pend = 0, m_tcnt = 0, m_ticks = 0;
    int   cyc = 0, first_cke = -1, init_refs = 0, n_ref = 0;
    bit   mode_seen = 0;

    function automatic ent_t mk(logic cke, logic [3:0] p, logic [11:0] a, logic rdy,
                                logic srv, logic [3:0] tag);
        ent_t e;
        e.cke = cke; e.pins = p; e.addr = a; e.rdy = rdy; e.srv = srv; e.tag = tag;
        return e;
    endfunction

    task automatic build_init();
        for (int i = 0; i < PWR; i++) m_q.push_back(mk(0, P_SLEEP, 0, 0, 0, 1));   // R1
        m_q.push_back(mk(1, P_NOP, 0, 0, 0, 2));                                    // R2
        m_q.push_back(mk(1, P_PRE, 12'h400, 0, 0, 2));
        for (int i = 0; i < RP - 1; i++) m_q.push_back(mk(1, P_NOP, 0, 0, 0, 3));  // R3
        for (int k = 0; k < 8; k++) begin                                          // R4
            m_q.push_back(mk(1, P_REF, 0, 0, 0, 4));
            for (int i = 0; i < RC - 1; i++) m_q.push_back(mk(1, P_NOP, 0, 0, 0, 3));
        end
        m_q.push_back(mk(1, P_MRS, {5'b0, cfg_cas_lat, cfg_interleave, cfg_burst_len}, 0, 0, 5)); // R5
        for (int i = 0; i < MRD - 1; i++) m_q.push_back(mk(1, P_NOP, 0, 0, 0, 6)); // R6
    endtask

    task automatic push_refresh();                                                  // R9
        m_q.push_back(mk(1, P_PRE, 12'h400, 0, 0, 9));
        for (int i = 0; i < RP - 1; i++) m_q.push_back(mk(1, P_NOP, 0, 0, 0, 3));
        m_q.push_back(mk(1, P_REF, 0, 0, 1, 9));
        for (int i = 0; i < RC - 1; i++) m_q.push_back(mk(1, P_NOP, 0, 0, 0, 3));
    endtask

    always @(negedge clk) begin
        ent_t e;
        bit idle, tick, exp_req;
        if (!rst_n) begin
            m_q.delete(); m_built = 0; m_run = 0; m_pend = 0; m_tcnt = 0;
            cyc = 0; first_cke = -1; init_refs = 0; mode_seen = 0;
            // R1: quiet pins during reset
            chk(sd_cke == 0 && pins == P_SLEEP && !ready && !ref_req, 1, "reset pins",
                {sd_cke, pins, ready, ref_req}, {1'b0, P_SLEEP, 2'b00});
        end else begin
            if (!m_built) begin build_init(); m_built = 1; end
            idle = (m_q.size() == 0);
            e = idle ? mk(1, P_NOP, 0, 1, 0, 6) : m_q[0];
            if (idle) m_run = 1;
            tick = m_run && (m_tcnt == REFI - 1);
            exp_req = idle && (m_pend > 0);
            chk({sd_cke, pins, sd_addr, ready} == {e.cke, e.pins, e.addr, e.rdy} &&
                ref_req == exp_req, exp_req ? 8 : int'(e.tag), "pins/addr/ready/req",
                {sd_cke, pins, sd_addr, ready, ref_req}, {e.cke, e.pins, e.addr, e.rdy, exp_req});
            if (idle && m_pend > 0 && ref_grant) push_refresh();
            if (tick) m_ticks++;
            if (tick && !(!idle && e.srv)) begin if (m_pend < PMAX) m_pend++; end  // R10
            else if (!idle && e.srv && !tick) m_pend--;
            if (m_run) m_tcnt = tick ? 0 : m_tcnt + 1;
            if (!idle) void'(m_q.pop_front());
            // Explicit monitors
            if (sd_cke && first_cke < 0) begin
                first_cke = cyc;
                chk(cyc == PWR, 1, "pause length before CKE", cyc, PWR); // R1
            end
            if (pins == P_REF) begin n_ref++; if (!mode_seen) init_refs++; end
            if (pins == P_MRS && !mode_seen) begin
                mode_seen = 1;
                chk(init_refs == 8, 4, "power-up refresh count", init_refs, 8); // R4
            end
            cyc++;
        end
    end

    task automatic tick_in(input logic g);
        @(posedge clk); #1 ref_grant = g;
    endtask

    task automatic wait_until_ready(input int limit);
        int k = 0;
        while (!ready && k < limit) begin @(negedge clk); k++; end
    endtask

    initial begin : main
        int k, snap_ref, snap_tick, exp_n;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        wait_until_ready(PWR + 200);
        chk(ready, 6, "ready after power-up", ready, 1); // R6
        // R7: first request exactly one interval after ready
        k = 0;
        while (!ref_req && k < REFI + 10) begin @(negedge clk); k++; end
        chk(k == REFI, 7, "first request delay", k, REFI);
        // grant on the cycle the request is seen (R9)
        tick_in(1);
        repeat (3 * REFI) @(posedge clk);
        #1 ref_grant = 0;
        // R8: wait for a fresh request, service it once, then grant with nothing pending
        @(negedge clk);
        k = 0;
        while (!ref_req && k < 2 * REFI) begin @(negedge clk); k++; end
        tick_in(1); tick_in(0);
        wait_until_ready(50);
        repeat (3) @(negedge clk);
        tick_in(1); tick_in(0);
        @(negedge clk);
        chk(ready && pins == P_NOP && !ref_req, 8, "grant without request ignored",
            {ready, pins}, {1'b1, P_NOP});
        // R10: leave requests ungranted until the counter saturates
        repeat (9 * REFI) @(posedge clk);
        @(negedge clk);
        chk(ref_req, 10, "request pending after long hold", ref_req, 1);
        snap_ref = n_ref; snap_tick = m_ticks;
        tick_in(1);
        @(negedge clk);
        k = 0;
        while (!(ready && !ref_req) && k < 200) begin @(negedge clk); k++; end
        exp_n = PMAX + (m_ticks - snap_tick);
        chk(n_ref - snap_ref == exp_n, 10, "refreshes served after saturation",
            n_ref - snap_ref, exp_n);
        tick_in(0);
        // Second power-up with another configuration (R5)
        @(posedge clk); #1 rst_n = 0;
        cfg_burst_len = 3'b111; cfg_interleave = 1; cfg_cas_lat = 3'b011;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        k = 0;
        while (pins != P_MRS && k < PWR + 200) begin @(negedge clk); k++; end
        chk(pins == P_MRS && sd_addr == 12'h03F, 5, "mode word, interleave/full page/CL3",
            sd_addr, 12'h03F);
        wait_until_ready(20);
        chk(ready, 6, "ready after second power-up", ready, 1);
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule